// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Cell

This block is one output cell of a small programmable logic array that runs with registers enabled. It receives the array's literal lines, which carry each signal in true and complement form. It also receives the cell's own AND-array fuse row for each product term, a two-bit architecture code and a polarity bit. From these it forms eight product terms and routes them according to the architecture code.

With the registered code, all eight terms are ORed and captured by a flip-flop on the shared clock. The pad shows the inverted flip-flop output, and the shared active-low enable pin gates the driver. With the combinatorial code, term 0 becomes the driver enable. The other seven terms are ORed, and the polarity bit sets the level seen at the pad. With the input code, the driver stays off and the pad value is returned to the array.

A synchronous active-high reset clears the flip-flop, so a run starts from a known state.

Top module: `sop_out_cell`

## Requirements
- R1: Product term k is 1 exactly when every literal j whose fuse bit `fuse_i[k*LITS+j]` is 1 (intact) is also 1. A row with every fuse intact gives 0 whatever the literals are. A row with every fuse blown (all 0) gives 1.
- R2: With `mode_i` = 2'b00 (registered), the flip-flop loads the OR of all eight terms, term 0 included, at each rising clock edge. The pad output does not change before that edge.
- R3: In registered mode `pad_o` is the inverse of the flip-flop output, and `fb_o` equals the flip-flop output.
- R4: In registered mode `pad_oe_o` is the inverse of `oe_n_i`. The enable is 1 when the pin is low and 0 when it is high.
- R5: With `mode_i` = 2'b01 (combinatorial), `pad_oe_o` equals term 0 and the sum is the OR of terms 1 to 7 only. `pad_o` equals the sum when `pol_hi_i` is 1 and its inverse when `pol_hi_i` is 0. The output follows the inputs in the same cycle.
- R6: With `mode_i` = 2'b10 or 2'b11 (input), `pad_oe_o` is 0 and `pad_o` is 0 whatever the terms are.
- R7: In combinatorial and input modes, `fb_o` equals `pad_i`.
- R8: While `mode_i` is not 2'b00, the flip-flop keeps its value. On a return to registered mode, the pad shows the value that was held before the next clock edge.
- R9: When `rst_i` is sampled high at a rising edge, the flip-flop is cleared. In registered mode that gives `pad_o` = 1 and `fb_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared device clock |
| rst_i | input | 1 | Synchronous power-up reset, active high |
| oe_n_i | input | 1 | Shared output enable for registered cells, active low |
| mode_i | input | 2 | Architecture code: 00 registered, 01 combinatorial, 10/11 input |
| pol_hi_i | input | 1 | Combinatorial polarity: 1 active high, 0 active low |
| lit_i | input | LITS | Array literal lines (true and complement forms) |
| fuse_i | input | TERMS*LITS | Fuse rows; bit k*LITS+j is 1 when literal j feeds term k |
| pad_i | input | 1 | Value sensed on the pad |
| pad_o | output | 1 | Value driven toward the pad |
| pad_oe_o | output | 1 | Pad driver enable, active high |
| fb_o | output | 1 | Feedback into the array |

## Verification
The bench checks the two edge rows of the AND array. A design that fed literals straight into a fully intact row would read that term as 1 when every literal is high. A design that dropped blown literals wrongly would never give a 1 from a fully blown row.

Term 0 does two different jobs depending on the mode, and the bench looks at both. Leaving term 0 out of the registered sum would lose a capture. Leaving it in the combinatorial sum would let the enable term also drive the data.

Switching away from registered mode and back checks that the flip-flop holds. A design that kept clocking it would show fresh data instead of the held value. Both input codes are checked for a driver that stays off.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;
  typedef enum logic [1:0] {
    MODE_REG    = 2'b00,
    MODE_COMB   = 2'b01,
    MODE_IN     = 2'b10,
    MODE_IN_ALT = 2'b11
  } cell_mode_e;
endpackage

// File: rtl/sop_term_array.sv
module sop_term_array #(
  parameter int LITS  = 32,
  parameter int TERMS = 8
) (
  input  logic [LITS-1:0]       lit_i,
  input  logic [TERMS*LITS-1:0] fuse_i,
  output logic [TERMS-1:0]      term_o
);
  for (genvar k = 0; k < TERMS; k++) begin : g_term
    logic [LITS-1:0] row;
    assign row = fuse_i[k*LITS +: LITS];
    // A fully intact row is forced false; blown fuses drop out of the AND.
    assign term_o[k] = ~(&row) & (&(lit_i | ~row));
  end
endmodule

// File: rtl/sop_sum_select.sv
module sop_sum_select #(
  parameter int TERMS = 8
) (
  input  logic [TERMS-1:0] term_i,
  output logic             reg_sum_o,
  output logic             comb_sum_o,
  output logic             comb_oe_o
);
  assign reg_sum_o  = |term_i;
  assign comb_sum_o = |term_i[TERMS-1:1];
  assign comb_oe_o  = term_i[0];
endmodule

// File: rtl/sop_cell_reg.sv
module sop_cell_reg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i)     q_o <= 1'b0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/sop_out_cell.sv
module sop_out_cell #(
  parameter int LITS  = 32,
  parameter int TERMS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    oe_n_i,
  input  logic [1:0]              mode_i,
  input  logic                    pol_hi_i,
  input  logic [LITS-1:0]         lit_i,
  input  logic [TERMS*LITS-1:0]   fuse_i,
  input  logic                    pad_i,
  output logic                    pad_o,
  output logic                    pad_oe_o,
  output logic                    fb_o
);
  import sop_cell_pkg::*;

  localparam int FUSES = TERMS * LITS;

  cell_mode_e       mode;
  logic [TERMS-1:0] term_w;
  logic             reg_sum_w;
  logic             comb_sum_w;
  logic             comb_oe_w;
  logic             q_w;
  logic             is_reg;

  assign mode   = cell_mode_e'(mode_i);
  assign is_reg = (mode == MODE_REG);

  sop_term_array #(.LITS(LITS), .TERMS(TERMS)) u_terms (
    .lit_i  (lit_i),
    .fuse_i (fuse_i[FUSES-1:0]),
    .term_o (term_w)
  );

  sop_sum_select #(.TERMS(TERMS)) u_sums (
    .term_i     (term_w),
    .reg_sum_o  (reg_sum_w),
    .comb_sum_o (comb_sum_w),
    .comb_oe_o  (comb_oe_w)
  );

  sop_cell_reg u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (is_reg),
    .d_i   (reg_sum_w),
    .q_o   (q_w)
  );

  always_comb begin
    unique case (mode)
      MODE_REG: begin
        pad_o    = ~q_w;
        pad_oe_o = ~oe_n_i;
        fb_o     = q_w;
      end
      MODE_COMB: begin
        pad_o    = pol_hi_i ? comb_sum_w : ~comb_sum_w;
        pad_oe_o = comb_oe_w;
        fb_o     = pad_i;
      end
      default: begin
        pad_o    = 1'b0;
        pad_oe_o = 1'b0;
        fb_o     = pad_i;
      end
    endcase
  end
endmodule

// File: rtl/sop_out_cell_chk.sv
module sop_out_cell_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       oe_n_i,
  input logic [1:0] mode_i,
  input logic       pad_i,
  input logic       pad_o,
  input logic       pad_oe_o,
  input logic       fb_o,
  input logic       term0,
  input logic       reg_sum,
  input logic       q
);
  a_r2_reg_capture: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == 2'b00) |=> (q == $past(reg_sum)));

  a_r3_reg_pad: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == 2'b00) |-> (pad_o == !q && fb_o == q));

  a_r4_reg_oe: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == 2'b00) |-> (pad_oe_o == !oe_n_i));

  a_r5_comb_oe: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == 2'b01) |-> (pad_oe_o == term0));

  a_r6_input_off: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i[1]) |-> (!pad_oe_o && !pad_o));

  a_r7_fb_pad: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i != 2'b00) |-> (fb_o == pad_i));

  a_r8_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i != 2'b00) |=> (q == $past(q)));

  a_r9_reset: assert property (@(posedge clk_i)
    rst_i |=> (q == 1'b0));
endmodule

bind sop_out_cell sop_out_cell_chk u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .oe_n_i   (oe_n_i),
  .mode_i   (mode_i),
  .pad_i    (pad_i),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .fb_o     (fb_o),
  .term0    (term_w[0]),
  .reg_sum  (reg_sum_w),
  .q        (q_w)
);

// File: tb/sop_out_cell_tb_top.sv
`timescale 1ns/1ps
module sop_out_cell_tb_top;
  localparam int LITS  = 16;
  localparam int TERMS = 8;
  localparam logic [LITS-1:0] ALL_INTACT = '1;
  localparam logic [LITS-1:0] ALL_BLOWN  = '0;

  typedef struct {
    logic  pad;
    logic  oe;
    logic  fb;
    string req;
    string what;
  } exp_t;

  logic                  clk = 1'b0;
  logic                  rst_i;
  logic                  oe_n_i;
  logic [1:0]            mode_i;
  logic                  pol_hi_i;
  logic [LITS-1:0]       lit_i;
  logic [TERMS*LITS-1:0] fuse_i;
  logic                  pad_i;
  logic                  pad_o, pad_oe_o, fb_o;

  exp_t sb_q[$];
  event sb_ev;
  int   n_total = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  always #2.5 clk = ~clk;

  sop_out_cell #(.LITS(LITS), .TERMS(TERMS)) dut_i (
    .clk_i(clk), .rst_i(rst_i), .oe_n_i(oe_n_i), .mode_i(mode_i),
    .pol_hi_i(pol_hi_i), .lit_i(lit_i), .fuse_i(fuse_i), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o)
  );

  // Monitor: pops expectations and compares them with the ports.
  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() != 0) begin
        exp_t it;
        it = sb_q.pop_front();
        n_total++;
        if (pad_o !== it.pad || pad_oe_o !== it.oe || fb_o !== it.fb) begin
          n_fail++;
          $display("FAIL %s %s: got pad=%b oe=%b fb=%b, expected pad=%b oe=%b fb=%b",
                   it.req, it.what, pad_o, pad_oe_o, fb_o, it.pad, it.oe, it.fb);
        end
      end
    end
  end

  task automatic expect_out(input logic p, input logic o, input logic f,
                            input string req, input string what);
    exp_t it;
    #1;
    it.pad = p; it.oe = o; it.fb = f; it.req = req; it.what = what;
    sb_q.push_back(it);
    -> sb_ev;
    #1;
  endtask

  task automatic set_row(input int k, input logic [LITS-1:0] intact);
    fuse_i[k*LITS +: LITS] = intact;
  endtask

  task automatic next_cycle();
    @(negedge clk);
  endtask

  initial begin
    rst_i = 1'b1; oe_n_i = 1'b0; mode_i = 2'b00; pol_hi_i = 1'b1;
    lit_i = '0; fuse_i = '1; pad_i = 1'b0;
    repeat (3) next_cycle();
    rst_i = 1'b0;
    expect_out(1'b1, 1'b1, 1'b0, "R9", "reset state in registered mode");

    oe_n_i = 1'b1;
    expect_out(1'b1, 1'b0, 1'b0, "R4", "enable pin high turns driver off");
    oe_n_i = 1'b0;

    // Term 5 follows literal 2 only.
    set_row(5, 16'h0004);
    lit_i = 16'h0004;
    expect_out(1'b1, 1'b1, 1'b0, "R2", "no change before the edge");
    next_cycle();
    expect_out(1'b0, 1'b1, 1'b1, "R3", "captured 1 shows inverted at pad");
    lit_i = 16'h0000;
    next_cycle();
    expect_out(1'b1, 1'b1, 1'b0, "R2", "captured 0");

    // Term 0 alone (all blown) must reach the registered sum.
    set_row(5, ALL_INTACT);
    set_row(0, ALL_BLOWN);
    next_cycle();
    expect_out(1'b0, 1'b1, 1'b1, "R2", "term 0 feeds registered sum");

    // Combinatorial: term 0 enables, terms 1..7 all false.
    mode_i = 2'b01; pol_hi_i = 1'b1;
    expect_out(1'b0, 1'b1, 1'b0, "R5", "term 0 kept out of comb sum");
    pad_i = 1'b1;
    expect_out(1'b0, 1'b1, 1'b1, "R7", "feedback from pad in comb mode");
    repeat (3) next_cycle();
    mode_i = 2'b00;
    expect_out(1'b0, 1'b1, 1'b1, "R8", "flop held through comb mode");

    set_row(0, ALL_INTACT);
    lit_i = '1;
    next_cycle();
    expect_out(1'b1, 1'b1, 1'b0, "R1", "fully intact row is false");

    // Combinatorial data path: term 3 = lit0 & lit3.
    mode_i = 2'b01;
    set_row(0, ALL_BLOWN);
    set_row(3, 16'h0009);
    lit_i = 16'h0009;
    expect_out(1'b1, 1'b1, 1'b1, "R1", "term with both literals high");
    lit_i = 16'h0001;
    expect_out(1'b0, 1'b1, 1'b1, "R1", "term with one literal low");
    lit_i = 16'h0009; pol_hi_i = 1'b0;
    expect_out(1'b0, 1'b1, 1'b1, "R5", "active-low polarity inverts");
    lit_i = 16'h0001;
    expect_out(1'b1, 1'b1, 1'b1, "R5", "active-low polarity, sum 0");

    set_row(0, 16'h0002);
    lit_i = 16'h0009;
    expect_out(1'b0, 1'b0, 1'b1, "R5", "enable term false");
    lit_i = 16'h000B;
    expect_out(1'b0, 1'b1, 1'b1, "R5", "enable term true");

    // Input codes keep the driver off even with term 0 true.
    set_row(0, ALL_BLOWN);
    mode_i = 2'b10;
    expect_out(1'b0, 1'b0, 1'b1, "R6", "input code 10");
    mode_i = 2'b11; pad_i = 1'b0;
    expect_out(1'b0, 1'b0, 1'b0, "R6", "input code 11");
    expect_out(1'b0, 1'b0, 1'b0, "R7", "feedback from pad in input mode");

    // Reset again from a set flop.
    mode_i = 2'b00;
    next_cycle();
    expect_out(1'b0, 1'b1, 1'b1, "R2", "flop set before reset");
    rst_i = 1'b1;
    next_cycle();
    rst_i = 1'b0;
    expect_out(1'b1, 1'b1, 1'b0, "R9", "reset clears set flop");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule